// File: doc/BRIEF.md
# Low-Memory Boot Remapper

This block sits in front of a 32-bit memory bus and chooses what the bottom of the address map reaches. After power-on, an on-die boot ROM answers the lowest 8 KiB of addresses, and the matching region of external flash is hidden there. A fixed 8 KiB alias window at 0x03000000 always reaches that hidden flash region, so code running from the ROM can still read or program it.

A memory-mapped control register at 0xFFFFFB10 holds a two-bit remap field in bits 9:8. Writing a nonzero value there takes the boot ROM out of the map and puts external flash at address 0. The remap field has its own reset domain. A watchdog reset leaves it alone, while a power-on reset clears it. Firmware can therefore switch the map and then trigger the watchdog, and the processor restarts by fetching its reset vector from flash.

The block outputs a registered ROM select, a registered flash select, a write strobe and a translated device address. It does not contain the memories, and it does not arbitrate the bus.

Top module: `lowmem_remap`

## Requirements
- R1: A power-on reset clears the whole control register, including bits 9:8, so the boot ROM is mapped at address 0 again.
- R2: While bits 9:8 read 2'b00, an access to 0x00000000 through 0x00001FFF selects the ROM with the address as its offset.
- R3: While bits 9:8 hold any nonzero value (01, 10 or 11), an access to 0x00000000 through 0x00001FFF selects flash at the same offset.
- R4: An access from 0x00002000 through 0x00FFFFFF always selects flash, with the address as its offset.
- R5: An access from 0x03000000 through 0x03001FFF selects flash at offset (address - 0x03000000), so the offset always stays below 0x2000.
- R6: A read of the control register at byte address 0xFFFFFB10 returns its full 32-bit value on bus_rdata in the same cycle. All bits read back as last written. An access to the register selects no memory.
- R7: A register write takes effect at the next clock edge. The very next access is decoded with the new remap value.
- R8: A watchdog reset keeps bits 9:8 and clears every other bit of the control register.
- R9: A register write presented while either reset is asserted is ignored.
- R10: An access outside the three windows and the register selects nothing. bus_rdata is zero for every access except a read of the register.
- R11: rom_cs, flash_cs, mem_we and mem_addr are registered and appear one cycle after the access. With no valid access, or while either reset is asserted, they are all zero. mem_addr is zero whenever nothing is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high; clears everything |
| wdt_rst | input | 1 | Watchdog reset, synchronous, active high; spares the remap field |
| bus_valid | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Control register value during a register read, else zero |
| rom_cs | output | 1 | Registered boot ROM select |
| flash_cs | output | 1 | Registered external flash select |
| mem_we | output | 1 | Registered write strobe for the selected memory |
| mem_addr | output | 24 | Registered translated offset into the selected memory |

## Verification
The bench targets the edges of the low region (0x1FFC and 0x2000) and of the alias window (0x03001FFC and 0x03002000). A design with a wrong boundary sends these accesses to the ROM, to the wrong flash offset, or to no device at all. It writes each nonzero remap encoding. A design that tests only one bit of the field would keep the ROM mapped for one of them. It fires watchdog and power-on resets with a register write pending and then reads the register back. A design that merged the two reset domains, or that let a write through during reset, shows the wrong remap bits. It also places a low access right after a remap write, which exposes a design that lags the new map by one access.

// File: rtl/lowmem_remap_pkg.sv
package lowmem_remap_pkg;

  // Address region chosen by the decoder for one bus access
  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_ROM   = 3'd1,
    RG_FLASH = 3'd2,
    RG_ALIAS = 3'd3,
    RG_CTRL  = 3'd4
  } region_e;

endpackage

// File: rtl/lowmem_remap_ctrl.sv
module lowmem_remap_ctrl #(
  parameter int DW      = 32,
  parameter int MAP_LSB = 8,
  parameter int MAP_W   = 2
) (
  input  logic          clk,
  input  logic          por_rst,
  input  logic          wdt_rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic          map_flash
);

  localparam logic [DW-1:0] MAP_MASK = ((DW)'(1) << MAP_W) - 1 << MAP_LSB;

  logic [MAP_W-1:0] map_q;   // survives watchdog reset
  logic [DW-1:0]    rest_q;  // cleared by either reset, map bits kept zero

  // Remap field: power-on reset only; writes blocked while watchdog reset is active
  always_ff @(posedge clk) begin
    if (por_rst)
      map_q <= '0;
    else if (wr_en && !wdt_rst)
      map_q <= wdata[MAP_LSB +: MAP_W];
  end

  // Remaining bits: cleared by either reset domain
  always_ff @(posedge clk) begin
    if (por_rst || wdt_rst)
      rest_q <= '0;
    else if (wr_en)
      rest_q <= wdata & ~MAP_MASK;
  end

  assign ctrl_q    = rest_q | ((DW)'(map_q) << MAP_LSB);
  assign map_flash = |map_q;

  AST_POR_CLEARS_ALL: assert property (@(posedge clk)
    por_rst |=> (ctrl_q == '0)) else $error("power-on reset left register bits set"); // R1

  AST_WDT_KEEPS_MAP: assert property (@(posedge clk) disable iff (por_rst)
    wdt_rst |=> (map_q == $past(map_q))) else $error("watchdog reset altered remap field"); // R8

  AST_WDT_CLEARS_REST: assert property (@(posedge clk) disable iff (por_rst)
    wdt_rst |=> ((ctrl_q & ~MAP_MASK) == '0)) else $error("watchdog reset kept plain bits"); // R8

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (por_rst || wdt_rst)
    wr_en |=> (ctrl_q == $past(wdata))) else $error("register write did not land"); // R7

endmodule

// File: rtl/lowmem_remap_decode.sv
module lowmem_remap_decode
  import lowmem_remap_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          LOW_AW     = 13,
  parameter int          FLASH_AW   = 24,
  parameter logic [31:0] ALIAS_BASE = 32'h0300_0000,
  parameter logic [31:0] CTRL_ADDR  = 32'hFFFF_FB10
) (
  input  logic [AW-1:0]       addr,
  input  logic                map_flash,
  output region_e             region,
  output logic [FLASH_AW-1:0] offset
);

  logic hit_ctrl, hit_alias, hit_low, hit_flash;

  assign hit_ctrl  = (addr[AW-1:2] == CTRL_ADDR[AW-1:2]);
  assign hit_alias = (addr[AW-1:LOW_AW] == ALIAS_BASE[AW-1:LOW_AW]);
  assign hit_low   = (addr[AW-1:LOW_AW] == '0);
  assign hit_flash = (addr[AW-1:FLASH_AW] == '0);

  // Priority: register, alias window, low region, flash window
  always_comb begin
    region = RG_NONE;
    offset = '0;
    if (hit_ctrl) begin
      region = RG_CTRL;
    end else if (hit_alias) begin
      region = RG_ALIAS;
      offset = {{(FLASH_AW-LOW_AW){1'b0}}, addr[LOW_AW-1:0]};
    end else if (hit_low) begin
      region = map_flash ? RG_FLASH : RG_ROM;
      offset = addr[FLASH_AW-1:0];
    end else if (hit_flash) begin
      region = RG_FLASH;
      offset = addr[FLASH_AW-1:0];
    end
  end

endmodule

// File: rtl/lowmem_remap_outreg.sv
module lowmem_remap_outreg
  import lowmem_remap_pkg::*;
#(
  parameter int LOW_AW   = 13,
  parameter int FLASH_AW = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic                we,
  input  region_e             region,
  input  logic [FLASH_AW-1:0] offset,
  output logic                rom_cs,
  output logic                flash_cs,
  output logic                mem_we,
  output logic [FLASH_AW-1:0] mem_addr
);

  logic sel_rom, sel_flash;

  assign sel_rom   = valid && (region == RG_ROM);
  assign sel_flash = valid && ((region == RG_FLASH) || (region == RG_ALIAS));

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs   <= 1'b0;
      flash_cs <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
    end else begin
      rom_cs   <= sel_rom;
      flash_cs <= sel_flash;
      mem_we   <= we && (sel_rom || sel_flash);
      mem_addr <= (sel_rom || sel_flash) ? offset : '0;
    end
  end

  AST_ALIAS_REACHES_FLASH: assert property (@(posedge clk) disable iff (rst)
    (valid && region == RG_ALIAS) |=>
      (flash_cs && !rom_cs && mem_addr[FLASH_AW-1:LOW_AW] == '0))
    else $error("alias access not sent to low flash"); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !(rom_cs || flash_cs || mem_we))
    else $error("select asserted without an access"); // R11

endmodule

// File: rtl/lowmem_remap.sv
module lowmem_remap
  import lowmem_remap_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          AW         = 32,
  parameter int          LOW_AW     = 13,
  parameter int          FLASH_AW   = 24,
  parameter int          MAP_LSB    = 8,
  parameter int          MAP_W      = 2,
  parameter logic [31:0] ALIAS_BASE = 32'h0300_0000,
  parameter logic [31:0] CTRL_ADDR  = 32'hFFFF_FB10
) (
  input  logic                clk,
  input  logic                por_rst,
  input  logic                wdt_rst,
  input  logic                bus_valid,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                rom_cs,
  output logic                flash_cs,
  output logic                mem_we,
  output logic [FLASH_AW-1:0] mem_addr
);

  region_e             region;
  logic [FLASH_AW-1:0] offset;
  logic [DW-1:0]       ctrl_q;
  logic                map_flash;
  logic                reg_hit;
  logic                reg_wr;
  logic                any_rst;

  assign any_rst = por_rst || wdt_rst;
  assign reg_hit = bus_valid && (region == RG_CTRL);
  assign reg_wr  = reg_hit && bus_we;

  lowmem_remap_decode #(
    .AW(AW), .LOW_AW(LOW_AW), .FLASH_AW(FLASH_AW),
    .ALIAS_BASE(ALIAS_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_decode (
    .addr      (bus_addr),
    .map_flash (map_flash),
    .region    (region),
    .offset    (offset)
  );

  lowmem_remap_ctrl #(
    .DW(DW), .MAP_LSB(MAP_LSB), .MAP_W(MAP_W)
  ) u_ctrl (
    .clk       (clk),
    .por_rst   (por_rst),
    .wdt_rst   (wdt_rst),
    .wr_en     (reg_wr),
    .wdata     (bus_wdata),
    .ctrl_q    (ctrl_q),
    .map_flash (map_flash)
  );

  lowmem_remap_outreg #(
    .LOW_AW(LOW_AW), .FLASH_AW(FLASH_AW)
  ) u_out (
    .clk      (clk),
    .rst      (any_rst),
    .valid    (bus_valid),
    .we       (bus_we),
    .region   (region),
    .offset   (offset),
    .rom_cs   (rom_cs),
    .flash_cs (flash_cs),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
  );

  // Combinational register read path
  assign bus_rdata = (reg_hit && !bus_we) ? ctrl_q : '0;

  AST_ROM_ONLY_WHEN_UNMAPPED: assert property (@(posedge clk) disable iff (any_rst)
    rom_cs |-> (!$past(map_flash) && mem_addr[FLASH_AW-1:LOW_AW] == '0))
    else $error("ROM selected while flash mapped low"); // R2

  AST_REG_SELECTS_NOTHING: assert property (@(posedge clk) disable iff (any_rst)
    reg_hit |=> !(rom_cs || flash_cs))
    else $error("register access selected a memory"); // R6

  AST_ONE_DEVICE: assert property (@(posedge clk) disable iff (any_rst)
    !(rom_cs && flash_cs)) else $error("both devices selected"); // R4

endmodule

// File: tb/lowmem_remap_tb.sv
`timescale 1ns/1ps
module lowmem_remap_tb;

  localparam logic [31:0] CTRL  = 32'hFFFF_FB10;
  localparam logic [31:0] ALIAS = 32'h0300_0000;

  logic        clk = 1'b0;
  logic        por_rst = 1'b1, wdt_rst = 1'b0;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rom_cs, flash_cs, mem_we;
  logic [23:0] mem_addr;

  int checks = 0;
  int errors = 0;
  logic [31:0] model = '0;

  always #2 clk = ~clk;

  lowmem_remap u_dut (
    .clk(clk), .por_rst(por_rst), .wdt_rst(wdt_rst),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rom_cs(rom_cs), .flash_cs(flash_cs), .mem_we(mem_we), .mem_addr(mem_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected {rom, flash, offset} from the requirements
  function automatic logic [25:0] expect_sel(input logic [31:0] a, input logic [31:0] m);
    if (a == CTRL)                               return '0;                      // R6
    if (a >= ALIAS && a < ALIAS + 32'h2000)      return {2'b01, 24'(a - ALIAS)}; // R5
    if (a < 32'h2000)
      return (m[9:8] == 2'b00) ? {2'b10, a[23:0]} : {2'b01, a[23:0]};           // R2 R3
    if (a < 32'h0100_0000)                       return {2'b01, a[23:0]};        // R4
    return '0;                                                                  // R10
  endfunction

  task automatic access(input logic [31:0] a, input bit we, input logic [31:0] d, input string tag);
    logic [25:0] e;
    logic [31:0] erd;
    logic        ewe;
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    erd = (!we && a == CTRL) ? model : 32'h0;
    chk(bus_rdata == erd, (a == CTRL) ? {tag, " R6 rdata"} : {tag, " R10 rdata"}, bus_rdata, erd);
    e = expect_sel(a, model);
    ewe = we && (e[25] || e[24]);
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_we = 1'b0;
    chk({rom_cs, flash_cs, mem_addr} == e && mem_we == ewe, {tag, " R11 select"},
        {mem_we, rom_cs, flash_cs, mem_addr}, {ewe, e});
    if (we && a == CTRL) model = d;
  endtask

  task automatic pulse_reset(input bit por, input bit try_wr, input logic [31:0] d);
    @(negedge clk);
    if (por) por_rst = 1'b1; else wdt_rst = 1'b1;
    bus_valid = try_wr; bus_we = 1'b1; bus_addr = CTRL; bus_wdata = d;
    repeat (2) @(posedge clk);
    #1;
    chk(!(rom_cs || flash_cs || mem_we), "R11 quiet in reset", {rom_cs, flash_cs, mem_we}, 0);
    @(negedge clk);
    por_rst = 1'b0; wdt_rst = 1'b0; bus_valid = 1'b0; bus_we = 1'b0;
    model = por ? 32'h0 : (model & 32'h0000_0300);
  endtask

  task automatic idle_check();
    @(negedge clk);
    bus_valid = 1'b0;
    @(posedge clk);
    #1;
    chk(!(rom_cs || flash_cs || mem_we) && mem_addr == 0, "R11 idle",
        {rom_cs, flash_cs, mem_we, mem_addr}, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    pulse_reset(1'b1, 1'b0, 32'h0);
    access(CTRL, 1'b0, 0, "R1 reg after por");
    access(32'h0000_0000, 1'b0, 0, "R2 low start");
    access(32'h0000_1FFC, 1'b1, 0, "R2 low end");
    access(32'h0000_2000, 1'b0, 0, "R4 above low");
    access(32'h00FF_FFFC, 1'b1, 0, "R4 flash top");
    access(32'h0100_0000, 1'b0, 0, "R10 past flash");
    access(32'h02FF_FFFC, 1'b0, 0, "R10 below alias");
    access(32'h0300_0000, 1'b0, 0, "R5 alias start");
    access(32'h0300_1FFC, 1'b1, 0, "R5 alias end");
    access(32'h0300_2000, 1'b0, 0, "R10 past alias");
    idle_check();
    access(CTRL, 1'b1, 32'h0000_0100, "R7 write 01");
    access(32'h0000_0010, 1'b0, 0, "R7 next access");
    access(CTRL, 1'b0, 0, "R6 readback");
    access(CTRL, 1'b1, 32'hA5A5_5A5A, "R6 write pattern");
    access(CTRL, 1'b0, 0, "R6 pattern read");
    access(32'h0000_0004, 1'b0, 0, "R3 code 10");
    access(32'h0300_0004, 1'b0, 0, "R5 alias with remap");
    pulse_reset(1'b0, 1'b1, 32'h0);
    access(CTRL, 1'b0, 0, "R8 R9 after wdt");
    access(32'h0000_0000, 1'b0, 0, "R8 vector from flash");
    access(CTRL, 1'b1, 32'h0, "R7 unmap");
    access(32'h0000_0000, 1'b0, 0, "R7 rom back");
    access(CTRL, 1'b1, 32'h0000_0300, "R3 write 11");
    access(32'h0000_1000, 1'b1, 0, "R3 code 11");
    pulse_reset(1'b1, 1'b1, 32'hFFFF_FFFF);
    access(CTRL, 1'b0, 0, "R1 R9 after por");
    access(32'h0000_0000, 1'b0, 0, "R1 rom at zero");

    for (int i = 0; i < 600; i++) begin
      int unsigned cat;
      logic [31:0] r, a;
      bit we;
      cat = $urandom_range(0, 5);
      r = $urandom;
      we = r[31];
      if ($urandom_range(0, 39) == 0) begin
        pulse_reset($urandom_range(0, 3) == 0, 1'b1, $urandom);
        access(CTRL, 1'b0, 0, "R8 R1 random reset");
      end
      case (cat)
        0, 5: begin a = {19'h0, r[12:2], 2'b00}; access(a, we, 0, "R2 R3 random low"); end
        1: begin
          a = {8'h00, r[23:2], 2'b00};
          if (a < 32'h2000) a = a | 32'h2000;
          access(a, we, 0, "R4 random flash");
        end
        2: begin a = ALIAS | (r & 32'h0000_1FFC); access(a, we, 0, "R5 random alias"); end
        3: access(CTRL, we, $urandom, "R6 R7 random reg");
        default: begin a = 32'h1000_0000 | (r & 32'h0FFF_FFFC); access(a, we, 0, "R10 random unmapped"); end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule